// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block sits between a single requester and a slower memory and holds recently used blocks in a direct-mapped line store. Every incoming word access is split into a tag, a line index and a word select. The access completes from the store when the addressed line is valid and its stored tag matches the incoming tag. Otherwise the controller talks to memory over a block-wide port. That port carries per-word write strobes and a one-cycle acknowledge.

A build parameter fixes one of two write policies for the whole controller:

- **Write-back with write-allocate.** Writes stay in the line and mark it dirty. A dirty line that must make room is first copied back to memory as a whole block.
- **Write-through with write-around.** Every write reaches memory as a single-word strobed write, and a write that misses leaves the store untouched.

The requester holds its request until a one-cycle ready pulse marks completion.

Top module: `dm_cache`

## Requirements
- R1: A reset invalidates every line and clears every dirty mark; after reset, `cpu_ready` and `mem_req` are low and the first access to any address misses.
- R2: With the default sizes (4 words of 32 bits per line, 8 lines), the word select is address bits [3:2], the line index is bits [6:4] and the tag is bits [31:7]. Two addresses with equal index but different tags compete for the same line.
- R3: A read hits only when the indexed line is valid and its tag equals the address tag. A read hit returns the word two cycles after the request is raised, with no memory traffic.
- R4: A read miss issues exactly one block read at the block-aligned address, holding `mem_req` and `mem_addr` steady until `mem_ack`. It then installs the block clean and returns the requested word.
- R5: In write-back mode, a write hit updates only the stored word and marks the line dirty. It produces no memory traffic, and a dirty line is always a valid line.
- R6: In write-back mode, a miss on a dirty line first writes the whole victim block to the victim's block address with all strobes set. Only then does it fetch the new block.
- R7: In write-back mode, a write miss fetches the block, then applies the write to the store only.
- R8: In write-through mode, a write hit updates the stored word and also issues one memory write. That write carries exactly one strobe bit, bit i set for word i of the block.
- R9: In write-through mode, a write miss issues only the single-word memory write. No line is allocated, so a following read of that address still misses.
- R10: `cpu_ready` is a one-cycle pulse, raised only when the access completes and never while `mem_req` is high. Let L be the memory response delay. Latency from raising the request is 2 cycles, plus L+2 for each block fetch, plus L+2 for a victim write-back, plus L+1 for a write-through word write.
- R11: A miss that replaces a clean or invalid line performs no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = block or word write, 0 = block read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | WORD_W*LINE_WORDS | Write block (word writes replicated in every lane) |
| mem_wstrb | output | LINE_WORDS | Per-word write enables |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | WORD_W*LINE_WORDS | Fetched block, valid with `mem_ack` |

## Verification
The bench builds the controller twice with default sizes: once with `WRITE_BACK=1` and once with `WRITE_BACK=0`. Both builds run the same directed and pseudo-random traffic over a 1 KB region, which is eight times the store capacity. That region gives tag aliasing on every line. In the write-back build, dirty-victim write-backs, write-allocate and the loss of dirty data on reset are reachable. In the write-through build, strobed word writes on both hits and misses are reachable, along with the rule that a write miss does not allocate.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FLUSH  = 2'd2,
    ST_FILL   = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8
) (
  input  logic [ADDR_W-1:0]                                   addr,
  input  logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_WORDS*WORD_W/8)-1:0] unused_tie,
  output logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_WORDS*WORD_W/8)-1:0] tag,
  output logic [$clog2(NUM_LINES)-1:0]                        idx,
  output logic [$clog2(LINE_WORDS)-1:0]                       wsel,
  output logic [ADDR_W-1:0]                                   blk_base
);
  localparam int BYTE_W = $clog2(WORD_W/8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(NUM_LINES);

  logic unused_ok;
  assign unused_ok = ^{unused_tie, addr[BYTE_W-1:0]};
  assign wsel      = addr[BYTE_W +: WSEL_W];
  assign idx       = addr[OFF_W +: IDX_W];
  assign tag       = addr[ADDR_W-1 : OFF_W+IDX_W];
  assign blk_base  = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(NUM_LINES)-1:0]  idx,
  output logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_WORDS*WORD_W/8)-1:0] rd_tag,
  output logic                          rd_valid,
  output logic                          rd_dirty,
  output logic [WORD_W*LINE_WORDS-1:0]  rd_line,
  input  logic                          dw_en,
  input  logic [LINE_WORDS-1:0]         dw_mask,
  input  logic [WORD_W*LINE_WORDS-1:0]  dw_line,
  input  logic                          mw_en,
  input  logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_WORDS*WORD_W/8)-1:0] mw_tag,
  input  logic                          mw_dirty
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - $clog2(LINE_WORDS*WORD_W/8);
  localparam int LINE_W = WORD_W * LINE_WORDS;

  logic [LINE_W-1:0]    data_mem [NUM_LINES];
  logic [TAG_W-1:0]     tag_mem  [NUM_LINES];
  logic [NUM_LINES-1:0] vld, drt;

  // data array: write-only clocked process, no reset, so it maps to RAM
  always_ff @(posedge clk) begin
    if (dw_en) begin
      for (int w = 0; w < LINE_WORDS; w++) begin
        if (dw_mask[w]) data_mem[idx][w*WORD_W +: WORD_W] <= dw_line[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mw_en) tag_mem[idx] <= mw_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      drt <= '0;
    end else if (mw_en) begin
      vld[idx] <= 1'b1;
      drt[idx] <= mw_dirty;
    end
  end

  assign rd_line  = data_mem[idx];
  assign rd_tag   = tag_mem[idx];
  assign rd_valid = vld[idx];
  assign rd_dirty = drt[idx];

  // R5
  dirty_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (drt & ~vld) == '0);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpu_valid,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [WORD_W-1:0]             cpu_wdata,
  output logic                          cpu_ready,
  output logic [WORD_W-1:0]             cpu_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [WORD_W*LINE_WORDS-1:0]  mem_wdata,
  output logic [LINE_WORDS-1:0]         mem_wstrb,
  input  logic                          mem_ack,
  input  logic [WORD_W*LINE_WORDS-1:0]  mem_rdata,
  output logic [$clog2(NUM_LINES)-1:0]  st_idx,
  input  logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_WORDS*WORD_W/8)-1:0] rd_tag,
  input  logic                          rd_valid,
  input  logic                          rd_dirty,
  input  logic [WORD_W*LINE_WORDS-1:0]  rd_line,
  output logic                          dw_en,
  output logic [LINE_WORDS-1:0]         dw_mask,
  output logic [WORD_W*LINE_WORDS-1:0]  dw_line,
  output logic                          mw_en,
  output logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_WORDS*WORD_W/8)-1:0] mw_tag,
  output logic                          mw_dirty
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = $clog2(LINE_WORDS*WORD_W/8);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;

  dmc_state_e         st;
  logic [ADDR_W-1:0]  q_addr;
  logic               q_we;
  logic [WORD_W-1:0]  q_wdata;
  logic               flush_word;

  logic [TAG_W-1:0]   q_tag;
  logic [IDX_W-1:0]   q_idx;
  logic [WSEL_W-1:0]  q_wsel;
  logic [ADDR_W-1:0]  q_blk;
  logic               hit;
  logic [WORD_W-1:0]  hit_word;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_split (
    .addr(q_addr), .unused_tie('0), .tag(q_tag), .idx(q_idx), .wsel(q_wsel), .blk_base(q_blk)
  );

  assign st_idx   = q_idx;
  assign hit      = rd_valid && (rd_tag == q_tag);
  assign hit_word = rd_line[q_wsel*WORD_W +: WORD_W];

  // store write controls
  always_comb begin
    dw_en    = 1'b0;
    dw_mask  = '0;
    dw_line  = '0;
    mw_en    = 1'b0;
    mw_tag   = q_tag;
    mw_dirty = 1'b0;
    if (st == ST_LOOKUP && hit && q_we) begin
      dw_en   = 1'b1;
      dw_mask = LINE_WORDS'(1) << q_wsel;
      dw_line = {LINE_WORDS{q_wdata}};
      if (WRITE_BACK) begin
        mw_en    = 1'b1;
        mw_dirty = 1'b1;
      end
    end else if (st == ST_FILL && mem_ack) begin
      dw_en   = 1'b1;
      dw_mask = '1;
      dw_line = mem_rdata;
      mw_en   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      q_addr     <= '0;
      q_we       <= 1'b0;
      q_wdata    <= '0;
      flush_word <= 1'b0;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_wstrb  <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (st)
        ST_IDLE: if (cpu_valid) begin
          q_addr  <= cpu_addr;
          q_we    <= cpu_we;
          q_wdata <= cpu_wdata;
          st      <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (q_we && !WRITE_BACK) begin
            // write-through: single-word write on hit and on miss alike
            mem_req    <= 1'b1;
            mem_we     <= 1'b1;
            mem_addr   <= q_blk;
            mem_wdata  <= {LINE_WORDS{q_wdata}};
            mem_wstrb  <= LINE_WORDS'(1) << q_wsel;
            flush_word <= 1'b1;
            st         <= ST_FLUSH;
          end else if (hit) begin
            if (!q_we) cpu_rdata <= hit_word;
            cpu_ready <= 1'b1;
            st        <= ST_IDLE;
          end else if (WRITE_BACK && rd_valid && rd_dirty) begin
            mem_req    <= 1'b1;
            mem_we     <= 1'b1;
            mem_addr   <= {rd_tag, q_idx, {OFF_W{1'b0}}};
            mem_wdata  <= rd_line;
            mem_wstrb  <= '1;
            flush_word <= 1'b0;
            st         <= ST_FLUSH;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= q_blk;
            st       <= ST_FILL;
          end
        end
        ST_FLUSH: if (mem_ack) begin
          if (flush_word) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_ready <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            mem_we   <= 1'b0;
            mem_addr <= q_blk;
            st       <= ST_FILL;
          end
        end
        ST_FILL: if (mem_ack) begin
          mem_req <= 1'b0;
          st      <= ST_LOOKUP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_ready && !mem_req));
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R10
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);

  generate
    if (WRITE_BACK) begin : g_wb_chk
      // R6
      full_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wstrb == '1));
    end else begin : g_wt_chk
      // R8
      single_word_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($countones(mem_wstrb) == 1));
    end
  endgenerate
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpu_valid,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [WORD_W-1:0]             cpu_wdata,
  output logic                          cpu_ready,
  output logic [WORD_W-1:0]             cpu_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [WORD_W*LINE_WORDS-1:0]  mem_wdata,
  output logic [LINE_WORDS-1:0]         mem_wstrb,
  input  logic                          mem_ack,
  input  logic [WORD_W*LINE_WORDS-1:0]  mem_rdata
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - $clog2(LINE_WORDS*WORD_W/8);
  localparam int LINE_W = WORD_W * LINE_WORDS;

  logic [IDX_W-1:0]      st_idx;
  logic [TAG_W-1:0]      rd_tag, mw_tag;
  logic                  rd_valid, rd_dirty, dw_en, mw_en, mw_dirty;
  logic [LINE_W-1:0]     rd_line, dw_line;
  logic [LINE_WORDS-1:0] dw_mask;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
    .NUM_LINES(NUM_LINES), .WRITE_BACK(WRITE_BACK)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_idx(st_idx), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_line(rd_line), .dw_en(dw_en), .dw_mask(dw_mask), .dw_line(dw_line),
    .mw_en(mw_en), .mw_tag(mw_tag), .mw_dirty(mw_dirty)
  );

  dmc_line_store #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_store (
    .clk(clk), .rst(rst), .idx(st_idx),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_line(rd_line),
    .dw_en(dw_en), .dw_mask(dw_mask), .dw_line(dw_line),
    .mw_en(mw_en), .mw_tag(mw_tag), .mw_dirty(mw_dirty)
  );
endmodule

// File: tb/dm_cache_tb_core.sv
module dm_cache_tb_core #(
  parameter bit WB = 1'b1
) (
  input  logic clk,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  localparam int LAT = 2;

  logic         rst;
  logic         cpu_valid, cpu_we, cpu_ready;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic [3:0]   mem_wstrb;

  dm_cache #(.WRITE_BACK(WB)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem   [256];
  logic [31:0] r_mem [256];
  logic [31:0] m_data [8][4];
  int          m_tag [8];
  bit          m_valid [8];
  bit          m_dirty [8];
  int          cnt, rd_cnt, wr_cnt;

  // memory responder: one-cycle ack LAT+1 negedges after a request appears
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (cnt == LAT) begin
        cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_cnt++;
          for (int w = 0; w < 4; w++)
            if (mem_wstrb[w]) mem[mem_addr[9:4]*4+w] = mem_wdata[w*32 +: 32];
        end else begin
          rd_cnt++;
          for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mem[mem_addr[9:4]*4+w];
        end
      end else begin
        cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s wb=%0d %s: actual=%0h expected=%0h", req, WB, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cpu_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      m_valid[i] = 1'b0;
      m_dirty[i] = 1'b0;
    end
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R1", "outputs after reset",
        {30'd0, cpu_ready, mem_req}, 32'd0);
  endtask

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       input string ovr = "");
    int idx, tg, ws, blk, lat, erd, ewr, n, rd0, wr0;
    bit hit;
    logic [31:0] exp_rd;
    string lbl, dlbl;
    idx = int'(a[6:4]); tg = int'(a[9:7]); ws = int'(a[3:2]); blk = int'(a[9:4]);
    hit = m_valid[idx] && (m_tag[idx] == tg);
    lat = 2; erd = 0; ewr = 0; exp_rd = '0;
    dlbl = hit ? "R3" : "R4";
    if (hit) lbl = we ? (WB ? "R5" : "R8") : "R3";
    else if (we) lbl = WB ? "R7" : "R9";
    else lbl = m_valid[idx] ? "R11" : "R4";
    if (!hit && (WB || !we)) begin
      if (WB && m_valid[idx] && m_dirty[idx]) begin
        for (int w = 0; w < 4; w++) r_mem[(m_tag[idx]*8 + idx)*4 + w] = m_data[idx][w];
        ewr++;
        lat += LAT + 2;
        lbl = "R6";
      end
      for (int w = 0; w < 4; w++) m_data[idx][w] = r_mem[blk*4 + w];
      m_tag[idx] = tg; m_valid[idx] = 1'b1; m_dirty[idx] = 1'b0;
      erd++;
      lat += LAT + 2;
      hit = 1'b1;
    end
    if (we && !WB) begin
      if (hit) m_data[idx][ws] = wd;
      r_mem[a[9:2]] = wd;
      ewr++;
      lat += LAT + 1;
    end else if (we) begin
      m_data[idx][ws] = wd;
      m_dirty[idx] = 1'b1;
    end else begin
      exp_rd = m_data[idx][ws];
    end
    if (ovr != "") lbl = ovr;

    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_ready && n < 200);
    cpu_valid = 1'b0;
    chk(n == lat, "R10", "latency", n, lat);
    if (!we) chk(cpu_rdata == exp_rd, dlbl, "read data", cpu_rdata, exp_rd);
    chk(rd_cnt - rd0 == erd, lbl, "block fetches", rd_cnt - rd0, erd);
    chk(wr_cnt - wr0 == ewr, lbl, "memory writes", wr_cnt - wr0, ewr);
    chk(mem[a[9:2]] == r_mem[a[9:2]], lbl, "memory word", mem[a[9:2]], r_mem[a[9:2]]);
  endtask

  initial begin
    logic [15:0] lfsr;
    int mism;
    done = 1'b0; n_chk = 0; n_bad = 0; rd_cnt = 0; wr_cnt = 0; cnt = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 32'h5A000000 ^ (i * 32'h00010203);
      r_mem[i] = mem[i];
    end
    do_reset();
    // cold miss then hit (R1, R4, R3)
    do_op(1'b0, 32'h040, '0, "R1");
    do_op(1'b0, 32'h044, '0);
    // write hit: R5 in write-back, R8 in write-through
    do_op(1'b1, 32'h044, 32'hCAFE0001);
    do_op(1'b0, 32'h044, '0);
    // same index, other tag (R2): dirty victim R6 or clean R11
    do_op(1'b0, 32'h0C0, '0, "R2");
    do_op(1'b0, 32'h044, '0);
    do_op(1'b0, 32'h0C8, '0, "R11");
    // write miss: R7 allocates, R9 does not
    do_op(1'b1, 32'h218, 32'hBEEF0002);
    do_op(1'b0, 32'h218, '0, WB ? "R7" : "R9");
    do_op(1'b0, 32'h010, '0);
    do_op(1'b0, 32'h090, '0, "R2");
    // mid-run reset drops lines (and any dirty data)
    do_op(1'b1, 32'h048, 32'h0BAD0003);
    do_reset();
    do_op(1'b0, 32'h048, '0, "R1");
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op(lfsr[12], {22'd0, lfsr[9:2], 2'b00}, {lfsr, ~lfsr});
    end
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== r_mem[i]) mism++;
    chk(mism == 0, WB ? "R6" : "R8", "memory image mismatches", mism, 0);
    done = 1'b1;
  end
endmodule

// File: tb/dm_cache_tb_top.sv
module dm_cache_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic done_wb, done_wt;
  int   chk_wb, bad_wb, chk_wt, bad_wt;

  dm_cache_tb_core #(.WB(1'b1)) u_wb (.clk(clk), .done(done_wb), .n_chk(chk_wb), .n_bad(bad_wb));
  dm_cache_tb_core #(.WB(1'b0)) u_wt (.clk(clk), .done(done_wt), .n_chk(chk_wt), .n_bad(bad_wt));

  initial begin
    int cyc;
    int extra;
    cyc = 0;
    extra = 0;
    while (!(done_wb === 1'b1 && done_wt === 1'b1) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 150000) begin
      extra = 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
    end
    $display("test done: total=%0d bad=%0d", chk_wb + chk_wt + extra, bad_wb + bad_wt + extra);
    $finish;
  end
endmodule